// File: doc/BRIEF.md
# Interval Timer Host Access Sequencer

This block sits between a byte-wide host bus and three counting engines of a programmable interval timer. The host reaches it through a 2-bit address, single-cycle read and write strobes, and 8-bit write and read data buses. Address 3 takes command bytes. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. The counting engines are outside this block. Each engine gives the block its live 16-bit count and its output level. The block gives each engine a one-cycle load strobe with a 16-bit value, plus the configured counting mode and decimal flag.

A command byte has three roles. It can set up a channel's access mode, counting mode and decimal flag. It can freeze a channel's count for a later read. As a read-back command, it can freeze the count, the status, or both, of any set of channels at once.

The block sets the byte order for each channel. In low-only and high-only access, a single byte moves per transfer. In word access, the low byte moves first and then the high byte, with separate byte pointers for reads and for writes. A data read returns the first of these that is present:
- a captured status byte;
- a captured count;
- the live count.

Top module: `timer_access_seq`

## Requirements
- R1: After reset, `rd_data` is 0 and `load_stb` is 0. Every channel has counting mode 0, decimal flag 0 and word access mode. No status or count capture is pending, and both byte pointers point at the low byte.
- R2: A write to address 3 is a command byte. When field [7:6] is not 3 and field [5:4] is not 0, the command configures the channel numbered by [7:6]:
  - [5:4] sets the access mode: 1 is low byte only, 2 is high byte only, 3 is low byte then high byte;
  - [3:1] sets the counting mode;
  - [0] sets the decimal flag.
  The new `cnt_mode` and `bcd` values appear in the cycle after the write. Both byte pointers of that channel return to the low byte.
- R3: In low-only access, a data write loads the value {8'h00, byte}.
- R4: In high-only access, a data write loads the value {byte, 8'h00}.
- R5: In word access, the first data write only holds its byte. The second data write loads {second, first}. `load_stb` of that channel is high for exactly the one cycle after the loading write.
- R6: With nothing captured, a data read returns a byte of the live count:
  - low-only access returns the low byte;
  - high-only access returns the high byte;
  - word access returns the low and high bytes in turn.
  The byte appears on `rd_data` in the cycle after the read strobe and holds until the next read.
- R7: A command with [5:4] = 0 and [7:6] not 3 captures the live count of the channel selected by [7:6]. Reads return the captured count in the channel's access mode. In word access the low byte comes first, then the high byte. The capture is released after its last byte, and later reads see the live count.
- R8: A count capture request has no effect while a captured count of that channel is still unread.
- R9: A command with [7:6] = 3 is a read-back command:
  - bit 1+n selects channel n;
  - bit 5 = 0 requests a count capture;
  - bit 4 = 0 requests a status capture.
  One command can act on several channels.
- R10: The captured status byte is {output level, 0, access mode[1:0], counting mode[2:0], decimal flag}, taken at the command. A status request has no effect while status of that channel is still unread.
- R11: A data read returns pending status first and clears it. A pending captured count comes next, and the live count comes only when neither is pending.
- R12: A read of address 3 returns 8'h00 and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Register address: 0 to 2 channel data ports, 3 command |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, registered |
| live_count | input | 48 | Live counts, channel n at [16n+15:16n] |
| out_level | input | 3 | Output level of each channel |
| load_stb | output | 3 | Count load strobe per channel |
| load_val | output | 48 | Load value, channel n at [16n+15:16n] |
| cnt_mode | output | 9 | Counting mode, channel n at [3n+2:3n] |
| bcd | output | 3 | Decimal flag per channel |

## Verification
Each result has a fixed due cycle, one clock edge after the strobe that causes it:
- a read strobe sampled at one edge puts its byte on `rd_data` at that edge;
- a write that completes a load raises `load_stb` at the edge that samples it;
- a command's `cnt_mode` and `bcd` appear at that edge.

The driver applies strobes on the falling edge and keeps each one for exactly one cycle. For every read and every expected load, it queues the expected value. The monitor checks each read and each load on the falling edge that follows the sampling edge. A load strobe that arrives with no queued expectation counts as a failure, and so does a queue that is not empty at the end. Captures are checked by changing the live count between the capture command and the read.

// File: rtl/tas_pkg.sv
// Shared widths and encodings for the timer access sequencer.
package tas_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 16;
    localparam int MODE_W = 3;

    // Byte access modes; the same encoding names a pending count capture.
    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;
endpackage

// File: rtl/tas_cmd_decode.sv
// Command and strobe decoder.
// Turns one host strobe into per-channel requests: configuration write,
// count capture, status capture, data write and data read.
// Assumes strobes are single-cycle and never high together.
module tas_cmd_decode #(
    parameter int NCH = 3
) (
    input  logic [1:0]     addr,
    input  logic           wr_stb,
    input  logic           rd_stb,
    input  logic [7:0]     wr_data,
    output logic [NCH-1:0] cfg_we,
    output logic [NCH-1:0] cnt_req,
    output logic [NCH-1:0] sts_req,
    output logic [NCH-1:0] data_we,
    output logic [NCH-1:0] data_re
);
    localparam logic [1:0] CMD_ADDR = 2'd3;
    localparam logic [1:0] SEL_RB   = 2'd3;

    logic       cmd_hit;
    logic [1:0] sel;
    logic [1:0] acc;
    logic       is_rb;

    // Field split of the command byte.
    always_comb begin
        cmd_hit = wr_stb && (addr == CMD_ADDR);
        sel     = wr_data[7:6];
        acc     = wr_data[5:4];
        is_rb   = (sel == SEL_RB);
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        // Per-channel request generation.
        always_comb begin
            cfg_we[n]  = cmd_hit && !is_rb && (sel == 2'(n)) && (acc != 2'd0);
            cnt_req[n] = cmd_hit && ((!is_rb && (sel == 2'(n)) && (acc == 2'd0))
                                  || (is_rb && wr_data[n+1] && !wr_data[5]));
            sts_req[n] = cmd_hit && is_rb && wr_data[n+1] && !wr_data[4];
            data_we[n] = wr_stb && (addr == 2'(n));
            data_re[n] = rd_stb && (addr == 2'(n));
        end
    end
endmodule

// File: rtl/tas_chan_port.sv
// Per-channel register port.
// Holds the channel's configuration, write and read byte pointers,
// captured count, and captured status. Produces the load strobe and
// value, and exposes the byte that a data read would return now.
// Assumes at most one request per cycle.
module tas_chan_port
    import tas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_acc,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic              cfg_bcd,
    input  logic              cnt_req,
    input  logic              sts_req,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [CNT_W-1:0]  live_count,
    input  logic              out_level,
    output logic              load_stb,
    output logic [CNT_W-1:0]  load_val,
    output logic [MODE_W-1:0] cnt_mode,
    output logic              bcd,
    output logic [BYTE_W-1:0] rd_byte
);
    acc_e              acc_q;
    logic [MODE_W-1:0] mode_q;
    logic              bcd_q;
    logic              wr_hi_q;
    logic              rd_hi_q;
    logic [BYTE_W-1:0] lo_hold_q;
    acc_e              cap_q;
    logic [CNT_W-1:0]  cap_val_q;
    logic              sts_pend_q;
    logic [BYTE_W-1:0] sts_q;
    logic              load_stb_q;
    logic [CNT_W-1:0]  load_val_q;

    // Read byte selection: status first, then captured count, then live count.
    always_comb begin
        if (sts_pend_q)
            rd_byte = sts_q;
        else if (cap_q != ACC_LATCH)
            rd_byte = (cap_q == ACC_HI) ? cap_val_q[15:8] : cap_val_q[7:0];
        else if ((acc_q == ACC_HI) || ((acc_q == ACC_WORD) && rd_hi_q))
            rd_byte = live_count[15:8];
        else
            rd_byte = live_count[7:0];
    end

    // Configuration and byte pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= ACC_WORD;
            mode_q  <= '0;
            bcd_q   <= 1'b0;
            wr_hi_q <= 1'b0;
            rd_hi_q <= 1'b0;
        end else if (cfg_we) begin
            acc_q   <= acc_e'(cfg_acc);
            mode_q  <= cfg_mode;
            bcd_q   <= cfg_bcd;
            wr_hi_q <= 1'b0;
            rd_hi_q <= 1'b0;
        end else begin
            if (data_we && (acc_q == ACC_WORD))
                wr_hi_q <= !wr_hi_q;
            if (data_re && !sts_pend_q && (cap_q == ACC_LATCH) && (acc_q == ACC_WORD))
                rd_hi_q <= !rd_hi_q;
        end
    end

    // Write sequencing and load strobe generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_hold_q  <= '0;
            load_stb_q <= 1'b0;
            load_val_q <= '0;
        end else begin
            load_stb_q <= 1'b0;
            if (data_we) begin
                unique case (acc_q)
                    ACC_LO: begin
                        load_stb_q <= 1'b1;
                        load_val_q <= {8'h00, wbyte};
                    end
                    ACC_HI: begin
                        load_stb_q <= 1'b1;
                        load_val_q <= {wbyte, 8'h00};
                    end
                    ACC_WORD: begin
                        if (wr_hi_q) begin
                            load_stb_q <= 1'b1;
                            load_val_q <= {wbyte, lo_hold_q};
                        end else begin
                            lo_hold_q <= wbyte;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Count capture: taken only when none is pending, released after its last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q     <= ACC_LATCH;
            cap_val_q <= '0;
        end else if (cnt_req && (cap_q == ACC_LATCH)) begin
            cap_q     <= acc_q;
            cap_val_q <= live_count;
        end else if (data_re && !sts_pend_q && (cap_q != ACC_LATCH)) begin
            cap_q <= (cap_q == ACC_WORD) ? ACC_HI : ACC_LATCH;
        end
    end

    // Status capture: taken only when none is pending, cleared by one read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_pend_q <= 1'b0;
            sts_q      <= '0;
        end else if (sts_req && !sts_pend_q) begin
            sts_pend_q <= 1'b1;
            sts_q      <= {out_level, 1'b0, acc_q, mode_q, bcd_q};
        end else if (data_re) begin
            sts_pend_q <= 1'b0;
        end
    end

    assign load_stb = load_stb_q;
    assign load_val = load_val_q;
    assign cnt_mode = mode_q;
    assign bcd      = bcd_q;
endmodule

// File: rtl/timer_access_seq.sv
// Top of the timer host access sequencer.
// Decodes host strobes, runs one register port per channel, and registers
// the selected read byte. Assumes NCH <= 3, because address 3 is the
// command register, and assumes read and write strobes are exclusive.
module timer_access_seq
    import tas_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            addr,
    input  logic                  wr_stb,
    input  logic                  rd_stb,
    input  logic [BYTE_W-1:0]     wr_data,
    output logic [BYTE_W-1:0]     rd_data,
    input  logic [NCH*CNT_W-1:0]  live_count,
    input  logic [NCH-1:0]        out_level,
    output logic [NCH-1:0]        load_stb,
    output logic [NCH*CNT_W-1:0]  load_val,
    output logic [NCH*MODE_W-1:0] cnt_mode,
    output logic [NCH-1:0]        bcd
);
    logic [NCH-1:0]    cfg_we;
    logic [NCH-1:0]    cnt_req;
    logic [NCH-1:0]    sts_req;
    logic [NCH-1:0]    data_we;
    logic [NCH-1:0]    data_re;
    logic [BYTE_W-1:0] rd_byte [NCH];
    logic [BYTE_W-1:0] sel_byte;
    logic [BYTE_W-1:0] rd_q;

    tas_cmd_decode #(.NCH(NCH)) u_dec (
        .addr    (addr),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .wr_data (wr_data),
        .cfg_we  (cfg_we),
        .cnt_req (cnt_req),
        .sts_req (sts_req),
        .data_we (data_we),
        .data_re (data_re)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_port
        tas_chan_port u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_we     (cfg_we[n]),
            .cfg_acc    (wr_data[5:4]),
            .cfg_mode   (wr_data[3:1]),
            .cfg_bcd    (wr_data[0]),
            .cnt_req    (cnt_req[n]),
            .sts_req    (sts_req[n]),
            .data_we    (data_we[n]),
            .data_re    (data_re[n]),
            .wbyte      (wr_data),
            .live_count (live_count[n*CNT_W +: CNT_W]),
            .out_level  (out_level[n]),
            .load_stb   (load_stb[n]),
            .load_val   (load_val[n*CNT_W +: CNT_W]),
            .cnt_mode   (cnt_mode[n*MODE_W +: MODE_W]),
            .bcd        (bcd[n]),
            .rd_byte    (rd_byte[n])
        );
    end

    // Channel read mux; the command address reads as zero.
    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < NCH; i++)
            if (addr == 2'(i))
                sel_byte = rd_byte[i];
    end

    // Read data register, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_stb)
            rd_q <= sel_byte;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/tas_checker.sv
// Protocol checker for timer_access_seq, attached through bind.
// Watches only the top-level ports.
module tas_checker #(
    parameter int NCH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        addr,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic [7:0]        wr_data,
    input logic [7:0]        rd_data,
    input logic [NCH-1:0]    load_stb,
    input logic [NCH*16-1:0] load_val,
    input logic [NCH*3-1:0]  cnt_mode,
    input logic [NCH-1:0]    bcd
);
    // A load strobe follows a data write to the same channel.
    for (genvar n = 0; n < NCH; n++) begin : g_chk
        assert_load_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
            load_stb[n] |-> ($past(wr_stb) && ($past(addr) == 2'(n))));
        // The loaded value carries the last written byte in one of its halves.
        assert_load_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
            load_stb[n] |-> ((load_val[n*16+8 +: 8] == $past(wr_data))
                          || (load_val[n*16 +: 8] == $past(wr_data))));
    end

    // At most one channel loads in a cycle.
    assert_one_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb));

    // Read data changes only after a read strobe.
    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_stb) |-> $stable(rd_data));

    // Mode outputs change only after a command write.
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stb && (addr == 2'd3)) |-> ($stable(cnt_mode) && $stable(bcd)));

    // A read of the command address returns zero.
    assert_cmd_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_stb && (addr == 2'd3)) |-> (rd_data == 8'h00));
endmodule

bind timer_access_seq tas_checker #(.NCH(NCH)) u_tas_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .load_stb (load_stb),
    .load_val (load_val),
    .cnt_mode (cnt_mode),
    .bcd      (bcd)
);

// File: tb/timer_access_seq_test.sv
// Scoreboard bench for timer_access_seq.
module timer_access_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        addr = '0;
    logic              wr_stb = 1'b0;
    logic              rd_stb = 1'b0;
    logic [7:0]        wr_data = '0;
    logic [7:0]        rd_data;
    logic [NCH*16-1:0] live_count = '0;
    logic [NCH-1:0]    out_level = '0;
    logic [NCH-1:0]    load_stb;
    logic [NCH*16-1:0] load_val;
    logic [NCH*3-1:0]  cnt_mode;
    logic [NCH-1:0]    bcd;

    int checks = 0;
    int errors = 0;
    logic rd_seen = 1'b0;
    logic done = 1'b0;

    logic [7:0]  rd_exp_q [$];
    string       rd_tag_q [$];
    logic [17:0] ld_exp_q [$];
    string       ld_tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_access_seq #(.NCH(NCH)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .live_count (live_count),
        .out_level  (out_level),
        .load_stb   (load_stb),
        .load_val   (load_val),
        .cnt_mode   (cnt_mode),
        .bcd        (bcd)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wr_load(input logic [1:0] a, input logic [7:0] d,
                           input logic [15:0] v, input string tag);
        ld_exp_q.push_back({a, v});
        ld_tag_q.push_back(tag);
        wr(a, d);
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        rd_exp_q.push_back(exp);
        rd_tag_q.push_back(tag);
        addr = a; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    // Marks the read results due at this edge.
    always @(posedge clk) rd_seen <= rd_stb && rst_n;

    // Monitor: compares reads and loads with the queued expectations.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (rd_exp_q.size() == 0) begin
                check("unexpected read", 32'(rd_data), 32'hFFFF_FFFF);
            end else begin
                logic [7:0] e;
                string t;
                e = rd_exp_q.pop_front();
                t = rd_tag_q.pop_front();
                check(t, 32'(rd_data), 32'(e));
            end
        end
        for (int n = 0; n < NCH; n++) begin
            if (load_stb[n]) begin
                if (ld_exp_q.size() == 0) begin
                    check("unexpected load", 32'({2'(n), load_val[n*16 +: 16]}), 32'hFFFF_FFFF);
                end else begin
                    logic [17:0] e;
                    string t;
                    e = ld_exp_q.pop_front();
                    t = ld_tag_q.pop_front();
                    check(t, 32'({2'(n), load_val[n*16 +: 16]}), 32'(e));
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rd_data", 32'(rd_data), 32'h0);
        check("R1 load_stb", 32'(load_stb), 32'h0);
        check("R1 cnt_mode", 32'(cnt_mode), 32'h0);
        check("R1 bcd", 32'(bcd), 32'h0);

        // R1 default word access: two writes load ch0
        wr(2'd0, 8'h5A);
        wr_load(2'd0, 8'hC3, 16'hC35A, "R1 default word load");

        // R2 configure ch0 word mode 2; R5 word load
        wr(2'd3, 8'h34);
        @(negedge clk);
        check("R2 ch0 mode", 32'(cnt_mode[2:0]), 32'd2);
        wr(2'd0, 8'h34);
        wr_load(2'd0, 8'h12, 16'h1234, "R5 word load");
        // R2 ch1 low-only, mode 3, decimal; R3
        wr(2'd3, 8'h57);
        @(negedge clk);
        check("R2 ch1 mode", 32'(cnt_mode[5:3]), 32'd3);
        check("R2 ch1 bcd", 32'(bcd[1]), 32'd1);
        wr_load(2'd1, 8'hAB, 16'h00AB, "R3 low-only load");
        // R4 ch2 high-only
        wr(2'd3, 8'hA0);
        wr_load(2'd2, 8'hCD, 16'hCD00, "R4 high-only load");

        // R6 live reads
        live_count = {16'h2468, 16'h1357, 16'hBEEF};
        rd(2'd0, 8'hEF, "R6 word low");
        rd(2'd0, 8'hBE, "R6 word high");
        rd(2'd0, 8'hEF, "R6 word low again");
        rd(2'd1, 8'h57, "R6 low-only");
        rd(2'd2, 8'h24, "R6 high-only");

        // R7 count capture on ch0, R8 second request ignored
        live_count[15:0] = 16'h4321;
        wr(2'd3, 8'h00);
        live_count[15:0] = 16'h9999;
        wr(2'd3, 8'h00);
        rd(2'd0, 8'h21, "R7 captured low / R8");
        rd(2'd0, 8'h43, "R7 captured high / R8");
        rd(2'd0, 8'h99, "R7 released to live high");

        // R9/R10 read-back status and count on ch1 and ch2
        live_count[47:16] = {16'h7788, 16'h5566};
        out_level = 3'b110;
        wr(2'd3, 8'hCC);
        out_level = 3'b000;
        wr(2'd3, 8'hE4);
        live_count[47:16] = {16'h1F00, 16'h0102};
        rd(2'd1, 8'h97, "R10 ch1 status / R11 first");
        rd(2'd1, 8'h66, "R9 ch1 captured low / R11");
        rd(2'd1, 8'h02, "R11 ch1 live");
        rd(2'd2, 8'hA0, "R10 ch2 status");
        rd(2'd2, 8'h77, "R9 ch2 captured high");
        rd(2'd2, 8'h1F, "R11 ch2 live");

        // R9 count-only read-back on ch0
        live_count[15:0] = 16'hA5B6;
        wr(2'd3, 8'hD2);
        live_count[15:0] = 16'h0C0D;
        rd(2'd0, 8'hB6, "R9 count-only low");
        rd(2'd0, 8'hA5, "R9 count-only high");
        rd(2'd0, 8'h0D, "R9 live low after release");

        // R2 command resets read and write pointers
        wr(2'd3, 8'h34);
        rd(2'd0, 8'h0D, "R2 read pointer reset");
        wr(2'd0, 8'h77);
        wr(2'd3, 8'h34);
        wr(2'd0, 8'h11);
        wr_load(2'd0, 8'h22, 16'h2211, "R2 write pointer reset");

        // R12 command address read; no state change
        rd(2'd3, 8'h00, "R12 command read");
        rd(2'd0, 8'h0D, "R12 no pointer change");

        repeat (3) @(negedge clk);
        check("R5 load queue empty", 32'(ld_exp_q.size()), 32'd0);
        check("R6 read queue empty", 32'(rd_exp_q.size()), 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule